// File: doc/BRIEF.md
# Paged Address Translator with Page Status Tracking

This block sits between a CPU and its main memory and turns logical addresses in the lowest 4 MB into physical addresses. A 1024-entry translation table supplies a 10-bit physical frame number for each 4 KB logical page; the 12-bit page offset is carried through unchanged. Addresses at or above 4 MB are outside the paged region and leave the block exactly as they came in. The translated address is registered and appears one clock after the request.

Each table entry is 16 bits wide. Bit 15 is a write-enable flag that belongs to the permission logic and is never changed here. Bits 14:13 hold a two-bit page state: 0 absent, 1 present and untouched, 2 present and read, 3 present and written. Bits 12:10 are spare and bits 9:0 are the frame number. Every translated access reads the entry, and in the same cycle writes back an advanced page state when the state has to change. This keeps the accessed and dirty information current for the operating system's page-replacement code. A peek request translates without touching the state. The CPU reads and writes the table as 16-bit words through a 64 KB window at 0x400000. Inside that window the 2 KB table image repeats every 0x800 bytes, and each entry is stored high byte first.

Top module: `pgmap_xlate`

## Requirements
- R1: A request whose address is 0x400000 or above returns that same address on xl_addr one cycle later, with xl_absent low, and never changes the table.
- R2: xl_valid is high in exactly the cycle after each cycle with req_valid high. For an address below 0x400000, xl_addr is {2'b00, entry[9:0], req_addr[11:0]}, where the entry is selected by page index req_addr[21:12] as it stood before the request.
- R3: A non-peek access to a page in state 1 (entry bits 14:13) moves the page to state 2 on a read and to state 3 on a write. Bit 15 and bits 12:0 of the entry are left unchanged.
- R4: A page in state 2 moves to state 3 on a non-peek write. A read of a page in state 2 or 3, and a write of a page in state 3, leave the entry unchanged.
- R5: An access to a page in state 0 leaves the entry unchanged and raises xl_absent together with xl_valid.
- R6: A request with req_peek high returns the same translation and absent flag as a normal request but never changes the entry.
- R7: A CPU access with mcpu_addr in 0x400000–0x40FFFF addresses entry mcpu_addr[10:1], so the image repeats every 0x800 bytes. mcpu_be[1] writes entry bits 15:8 (the byte at the even address) and mcpu_be[0] writes bits 7:0. A read returns the entry on mcpu_rdata with mcpu_rvalid high one cycle later.
- R8: When a CPU table write and a state update occur in the same cycle, the CPU write is performed and the state update is discarded. The translation in that cycle still uses the entry's old contents.
- R9: A CPU access outside 0x400000–0x40FFFF does not change the table and does not raise mcpu_rvalid.
- R10: While reset is asserted, xl_valid, xl_absent and mcpu_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 24 | Logical byte address |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_peek | input | 1 | Translate without updating the page state |
| xl_valid | output | 1 | Translated address valid, one cycle after the request |
| xl_addr | output | 24 | Physical (or passed-through) address |
| xl_absent | output | 1 | Translated page was in state 0 |
| mcpu_valid | input | 1 | CPU table access strobe |
| mcpu_write | input | 1 | CPU table access is a write |
| mcpu_addr | input | 24 | CPU byte address of the table access |
| mcpu_be | input | 2 | Byte enables: [1] bits 15:8, [0] bits 7:0 |
| mcpu_wdata | input | 16 | CPU write data |
| mcpu_rvalid | output | 1 | CPU read data valid |
| mcpu_rdata | output | 16 | CPU read data |

## Verification
The assertions assume that every input is driven to a known value in every cycle after reset. They also assume that mcpu_addr bit 0 carries no meaning, because the table is reached only as 16-bit words. The bench changes its inputs only on falling edges, always drives every input, and builds table addresses from an entry index and a mirror number with bit 0 clear. Before any request is issued, the whole table is written with random contents, so every page state, including absent, is met with known data.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

  typedef enum logic [1:0] {
    PG_ABSENT = 2'd0,
    PG_CLEAN  = 2'd1,
    PG_READ   = 2'd2,
    PG_DIRTY  = 2'd3
  } pg_state_e;

  // Entry field positions; the permission block decodes the same layout.
  localparam int ST_LO  = 13;
  localparam int ST_HI  = 14;
  localparam int WE_BIT = 15;

endpackage

// File: rtl/pgmap_state_next.sv
module pgmap_state_next
  import pgmap_pkg::*;
#(
  parameter int ENTRY_W = 16
) (
  input  logic [ENTRY_W-1:0] cur_entry,
  input  logic               is_write,
  output logic [ENTRY_W-1:0] nxt_entry,
  output logic               changed
);

  pg_state_e cur_st;
  pg_state_e nxt_st;

  always_comb begin
    cur_st = pg_state_e'(cur_entry[ST_HI:ST_LO]);
    nxt_st = cur_st;
    unique case (cur_st)
      PG_ABSENT: nxt_st = PG_ABSENT;
      PG_CLEAN:  nxt_st = is_write ? PG_DIRTY : PG_READ;
      PG_READ:   nxt_st = is_write ? PG_DIRTY : PG_READ;
      PG_DIRTY:  nxt_st = PG_DIRTY;
      default:   nxt_st = cur_st;
    endcase
  end

  always_comb begin
    nxt_entry               = cur_entry;
    nxt_entry[ST_HI:ST_LO]  = nxt_st;
    changed                 = (nxt_st != cur_st);
  end

endmodule

// File: rtl/pgmap_ram.sv
module pgmap_ram #(
  parameter int DEPTH_W = 10,
  parameter int DATA_W  = 16
) (
  input  logic                clk,
  input  logic                we,
  input  logic [DATA_W/8-1:0] wbe,
  input  logic [DEPTH_W-1:0]  waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DEPTH_W-1:0]  ra_addr,
  output logic [DATA_W-1:0]   ra_data,
  input  logic [DEPTH_W-1:0]  rb_addr,
  output logic [DATA_W-1:0]   rb_data
);

  localparam int DEPTH = 1 << DEPTH_W;
  localparam int NB    = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] merged;

  assign old_word = mem[waddr];
  assign ra_data  = mem[ra_addr];
  assign rb_data  = mem[rb_addr];

  // Byte-lane merge: unselected lanes keep their stored value.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign merged[g*8 +: 8] = wbe[g] ? wdata[g*8 +: 8] : old_word[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= merged;
    end
  end

endmodule

// File: rtl/pgmap_win_dec.sv
module pgmap_win_dec #(
  parameter int              ADDR_W   = 24,
  parameter int              WIN_W    = 16,
  parameter int              IDX_W    = 10,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'h400000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam int IMG_W = IDX_W + 1;

  logic unused_bits;

  assign hit = (addr[ADDR_W-1:WIN_W] == WIN_BASE[ADDR_W-1:WIN_W]);
  assign idx = addr[IMG_W-1:1];

  // Mirror bits and the byte bit do not select anything.
  assign unused_bits = ^{addr[WIN_W-1:IMG_W], addr[0]};

endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
  import pgmap_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int PAGE_W  = 10,
  parameter int OFS_W   = 12,
  parameter int ENTRY_W = 16,
  parameter int WIN_W   = 16,
  parameter logic [ADDR_W-1:0] MAP_BASE = 24'h400000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic                 req_peek,
  output logic                 xl_valid,
  output logic [ADDR_W-1:0]    xl_addr,
  output logic                 xl_absent,
  input  logic                 mcpu_valid,
  input  logic                 mcpu_write,
  input  logic [ADDR_W-1:0]    mcpu_addr,
  input  logic [ENTRY_W/8-1:0] mcpu_be,
  input  logic [ENTRY_W-1:0]   mcpu_wdata,
  output logic                 mcpu_rvalid,
  output logic [ENTRY_W-1:0]   mcpu_rdata
);

  localparam int XL_W = PAGE_W + OFS_W;
  localparam int NB   = ENTRY_W / 8;

  // Request side decode
  logic [PAGE_W-1:0]  page;
  logic               translated;
  logic [ENTRY_W-1:0] rd_entry;
  logic [ENTRY_W-1:0] upd_entry;
  logic               upd_changed;
  pg_state_e          cur_state;
  pg_state_e          upd_state;
  logic               upd_fire;

  // CPU side decode
  logic               win_hit;
  logic [PAGE_W-1:0]  win_idx;
  logic [ENTRY_W-1:0] win_entry;
  logic               cpu_we;
  logic               rd_hit;

  // Table write port
  logic               ram_we;
  logic [NB-1:0]      ram_wbe;
  logic [PAGE_W-1:0]  ram_waddr;
  logic [ENTRY_W-1:0] ram_wdata;

  // Output registers
  logic               xl_valid_d, xl_valid_q;
  logic [ADDR_W-1:0]  xl_addr_d,  xl_addr_q;
  logic               xl_absent_d, xl_absent_q;
  logic               rvalid_d,  rvalid_q;
  logic [ENTRY_W-1:0] rdata_q;

  logic unused_top;

  assign page       = req_addr[XL_W-1:OFS_W];
  assign translated = ~|req_addr[ADDR_W-1:XL_W];

  pgmap_win_dec #(
    .ADDR_W   (ADDR_W),
    .WIN_W    (WIN_W),
    .IDX_W    (PAGE_W),
    .WIN_BASE (MAP_BASE)
  ) u_win (
    .addr (mcpu_addr),
    .hit  (win_hit),
    .idx  (win_idx)
  );

  pgmap_ram #(
    .DEPTH_W (PAGE_W),
    .DATA_W  (ENTRY_W)
  ) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .wbe     (ram_wbe),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .ra_addr (page),
    .ra_data (rd_entry),
    .rb_addr (win_idx),
    .rb_data (win_entry)
  );

  pgmap_state_next #(
    .ENTRY_W (ENTRY_W)
  ) u_next (
    .cur_entry (rd_entry),
    .is_write  (req_write),
    .nxt_entry (upd_entry),
    .changed   (upd_changed)
  );

  assign cur_state = pg_state_e'(rd_entry[ST_HI:ST_LO]);
  assign upd_state = pg_state_e'(upd_entry[ST_HI:ST_LO]);

  // Write-port arbitration: the CPU write wins, the state update is dropped.
  always_comb begin
    cpu_we   = mcpu_valid & mcpu_write & win_hit;
    rd_hit   = mcpu_valid & ~mcpu_write & win_hit;
    upd_fire = req_valid & translated & ~req_peek & upd_changed & ~cpu_we;
    ram_we   = cpu_we | upd_fire;
    if (cpu_we) begin
      ram_waddr = win_idx;
      ram_wdata = mcpu_wdata;
      ram_wbe   = mcpu_be;
    end else begin
      ram_waddr = page;
      ram_wdata = upd_entry;
      ram_wbe   = '1;
    end
  end

  // Next-state for the output registers
  always_comb begin
    xl_valid_d  = req_valid;
    xl_absent_d = req_valid & translated & (cur_state == PG_ABSENT);
    if (translated) begin
      xl_addr_d = {{(ADDR_W-XL_W){1'b0}}, rd_entry[PAGE_W-1:0], req_addr[OFS_W-1:0]};
    end else begin
      xl_addr_d = req_addr;
    end
    rvalid_d = rd_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid_q  <= 1'b0;
      xl_absent_q <= 1'b0;
      rvalid_q    <= 1'b0;
    end else begin
      xl_valid_q  <= xl_valid_d;
      xl_absent_q <= xl_absent_d;
      rvalid_q    <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_addr_q <= '0;
    end else if (req_valid) begin
      xl_addr_q <= xl_addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_hit) begin
      rdata_q <= win_entry;
    end
  end

  assign xl_valid    = xl_valid_q;
  assign xl_addr     = xl_addr_q;
  assign xl_absent   = xl_absent_q;
  assign mcpu_rvalid = rvalid_q;
  assign mcpu_rdata  = rdata_q;

  assign unused_top = ^{rd_entry[ENTRY_W-1:PAGE_W]};

  // Assertions
  AST_XL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> xl_valid);                                           // R2
  AST_XL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !xl_valid);                                         // R2
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !translated) |=> (xl_addr == $past(req_addr) && !xl_absent)); // R1
  AST_WE_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> (upd_entry[WE_BIT] == rd_entry[WE_BIT]));            // R3
  AST_STATE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> (upd_state > cur_state));                             // R4
  AST_ABSENT_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> (cur_state != PG_ABSENT));                            // R5
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> mcpu_rvalid);                                           // R7
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> !mcpu_rvalid);                                         // R9

endmodule

// File: tb/pgmap_xlate_tb.sv
`timescale 1ns/1ps
module pgmap_xlate_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] req_addr;
  logic        req_write;
  logic        req_peek;
  logic        xl_valid;
  logic [23:0] xl_addr;
  logic        xl_absent;
  logic        mcpu_valid;
  logic        mcpu_write;
  logic [23:0] mcpu_addr;
  logic [1:0]  mcpu_be;
  logic [15:0] mcpu_wdata;
  logic        mcpu_rvalid;
  logic [15:0] mcpu_rdata;

  int checks;
  int errors;
  bit done;

  logic [15:0] mdl [1024];

  pgmap_xlate u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_peek    (req_peek),
    .xl_valid    (xl_valid),
    .xl_addr     (xl_addr),
    .xl_absent   (xl_absent),
    .mcpu_valid  (mcpu_valid),
    .mcpu_write  (mcpu_write),
    .mcpu_addr   (mcpu_addr),
    .mcpu_be     (mcpu_be),
    .mcpu_wdata  (mcpu_wdata),
    .mcpu_rvalid (mcpu_rvalid),
    .mcpu_rdata  (mcpu_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] f_next(input logic [15:0] e, input bit wr);
    logic [15:0] n;
    n = e;
    case (e[14:13])
      2'd1: n[14:13] = wr ? 2'd3 : 2'd2;
      2'd2: n[14:13] = wr ? 2'd3 : 2'd2;
      default: n[14:13] = e[14:13];
    endcase
    return n;
  endfunction

  function automatic bit f_in_win(input logic [23:0] a);
    return a[23:16] == 8'h40;
  endfunction

  function automatic logic [23:0] f_maddr(input int idx, input int mir);
    return 24'h400000 | 24'((mir & 31) << 11) | 24'((idx & 1023) << 1);
  endfunction

  // One cycle of stimulus with outputs checked after the following edge.
  task automatic do_op(input bit rq, input logic [23:0] ra, input bit rw, input bit rpk,
                       input bit mv, input bit mw, input logic [23:0] ma,
                       input logic [1:0] mbe, input logic [15:0] md, input string tag);
    logic [23:0] exp_xa;
    bit          exp_ab;
    bit          exp_rv;
    logic [15:0] exp_rd;
    bit          tr;
    int          pg;
    int          mi;
    bit          cpu_w;
    tr = (ra < 24'h400000);
    pg = int'(ra[21:12]);
    mi = int'(ma[10:1]);
    exp_xa = tr ? {2'b00, mdl[pg][9:0], ra[11:0]} : ra;
    exp_ab = tr && (mdl[pg][14:13] == 2'd0);
    exp_rv = mv && !mw && f_in_win(ma);
    exp_rd = mdl[mi];
    cpu_w  = mv && mw && f_in_win(ma);

    @(negedge clk);
    req_valid  = rq;  req_addr  = ra; req_write = rw; req_peek = rpk;
    mcpu_valid = mv;  mcpu_write = mw; mcpu_addr = ma; mcpu_be = mbe; mcpu_wdata = md;
    @(posedge clk);
    #1;
    chk(xl_valid == rq, "R2", 32'(xl_valid), 32'(rq));
    if (rq) begin
      chk(xl_addr == exp_xa, tr ? "R2" : "R1", 32'(xl_addr), 32'(exp_xa));
      chk(xl_absent == exp_ab, tr ? "R5" : "R1", 32'(xl_absent), 32'(exp_ab));
    end
    chk(mcpu_rvalid == exp_rv, f_in_win(ma) ? "R7" : "R9", 32'(mcpu_rvalid), 32'(exp_rv));
    if (exp_rv) chk(mcpu_rdata == exp_rd, tag, 32'(mcpu_rdata), 32'(exp_rd));

    // Model update: CPU write first, state update only if no CPU write.
    if (cpu_w) begin
      if (mbe[1]) mdl[mi][15:8] = md[15:8];
      if (mbe[0]) mdl[mi][7:0]  = md[7:0];
    end else if (rq && tr && !rpk) begin
      mdl[pg] = f_next(mdl[pg], rw);
    end
    @(negedge clk);
    req_valid = 1'b0; mcpu_valid = 1'b0;
  endtask

  task automatic tbl_wr(input int idx, input logic [15:0] d);
    do_op(0, 24'h0, 0, 0, 1, 1, f_maddr(idx, 0), 2'b11, d, "R7");
  endtask

  task automatic tbl_rd(input int idx, input string tag);
    do_op(0, 24'h0, 0, 0, 1, 0, f_maddr(idx, 0), 2'b00, 16'h0, tag);
  endtask

  task automatic acc(input logic [23:0] a, input bit wr, input bit pk, input string tag);
    do_op(1, a, wr, pk, 0, 0, 24'h0, 2'b00, 16'h0, tag);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_v;
    checks = 0; errors = 0; done = 0;
    seed_v = int'($urandom(32'd20240418));
    req_valid = 0; req_addr = '0; req_write = 0; req_peek = 0;
    mcpu_valid = 0; mcpu_write = 0; mcpu_addr = '0; mcpu_be = '0; mcpu_wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk(xl_valid == 1'b0, "R10", 32'(xl_valid), 0);
    chk(xl_absent == 1'b0, "R10", 32'(xl_absent), 0);
    chk(mcpu_rvalid == 1'b0, "R10", 32'(mcpu_rvalid), 0);
    @(negedge clk);
    rst_n = 1;

    // Fill the whole table with random contents.
    for (int i = 0; i < 1024; i++) tbl_wr(i, 16'($urandom));

    // R3: clean page, read then write
    tbl_wr(5, 16'hA123);                 // WE=1, state 1, frame 0x123
    acc(24'h005ABC, 0, 0, "R2");
    tbl_rd(5, "R3");                     // expect 0xC123
    chk(mdl[5] == 16'hC123, "R3", 32'(mdl[5]), 32'hC123);
    acc(24'h005004, 1, 0, "R2");
    tbl_rd(5, "R4");                     // expect 0xE123
    tbl_wr(6, 16'h2077);                 // WE=0, state 1
    acc(24'h006000, 1, 0, "R3");
    tbl_rd(6, "R3");                     // expect 0x6077
    // R4: dirty and read pages
    acc(24'h005FFE, 0, 0, "R4");
    tbl_rd(5, "R4");
    tbl_wr(7, 16'h4001);
    acc(24'h007010, 0, 0, "R4");
    tbl_rd(7, "R4");
    // R5: absent page
    tbl_wr(8, 16'h9FFF);                 // state 0
    acc(24'h008123, 1, 0, "R5");
    tbl_rd(8, "R5");
    // R6: peek does not update
    tbl_wr(9, 16'h2055);
    acc(24'h009321, 1, 1, "R6");
    tbl_rd(9, "R6");
    // R1: pass-through, highest address, and boundary
    acc(24'h400000, 1, 0, "R1");
    acc(24'hFFFFFF, 0, 0, "R1");
    acc(24'h3FFFFF, 0, 0, "R2");
    // R7: mirror and byte lanes
    do_op(0, 0, 0, 0, 1, 1, f_maddr(11, 7), 2'b11, 16'h3456, "R7");
    tbl_rd(11, "R7");
    do_op(0, 0, 0, 0, 1, 1, f_maddr(11, 31), 2'b10, 16'hAB00, "R7");
    do_op(0, 0, 0, 0, 1, 0, f_maddr(11, 3), 2'b00, 16'h0, "R7");   // 0xAB56
    do_op(0, 0, 0, 0, 1, 1, f_maddr(11, 0), 2'b01, 16'h00CD, "R7");
    tbl_rd(11, "R7");                    // 0xABCD
    // R8: CPU write collides with a state update on the same page
    tbl_wr(12, 16'h2010);
    do_op(1, 24'h00C000, 1, 0, 1, 1, f_maddr(12, 0), 2'b11, 16'h2099, "R8");
    tbl_rd(12, "R8");                    // expect 0x2099
    // R9: accesses outside the window
    do_op(0, 0, 0, 0, 1, 1, 24'h410018, 2'b11, 16'hFFFF, "R9");
    do_op(0, 0, 0, 0, 1, 0, 24'h3F0018, 2'b00, 16'h0, "R9");
    tbl_rd(12, "R9");

    // Constrained random mix
    for (int n = 0; n < 6000; n++) begin
      int k;
      logic [23:0] ra;
      logic [23:0] ma;
      k  = int'($urandom % 8);
      ra = ($urandom % 4 != 0) ? 24'($urandom % 32'h400000) : 24'($urandom);
      ma = ($urandom % 8 != 0) ? f_maddr(int'($urandom), int'($urandom))
                               : (24'($urandom) & 24'hFFFFFE);
      case (k)
        0, 1, 2, 3: do_op(1, ra, bit'($urandom), ($urandom % 8 == 0), 0, 0, 24'h0, 2'b00, 16'h0, "R3");
        4: do_op(0, 24'h0, 0, 0, 1, 1, ma, 2'($urandom), 16'($urandom), "R7");
        5, 6: do_op(0, 24'h0, 0, 0, 1, 0, ma, 2'b00, 16'h0, "R4");
        default: do_op(1, ra, bit'($urandom), 0, 1, 1, ma, 2'($urandom), 16'($urandom), "R8");
      endcase
    end
    // Read back the full table against the model.
    for (int i = 0; i < 1024; i++) tbl_rd(i, "R4");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule